// File: doc/BRIEF.md
# Lock-Aware Fully Associative Translation Buffer

This block stores up to 64 address translations in a fully associative array. Each slot holds:

- a page-aligned virtual address;
- a two-bit page-size code;
- a context number;
- a three-bit partition number;
- a real-mode flag;
- a page table word, one bit of which marks the slot as locked.

A command port accepts one operation per cycle. The operations are:

- insert a translation, into a slot the block chooses or into a slot the command names;
- drop every slot that belongs to one context of one partition;
- drop the unlocked slots of one partition;
- flush the whole array.

Every multi-slot operation compares all slots in parallel and completes in the cycle it is accepted.

When the block chooses the slot itself, an invalid slot comes first. Otherwise a round-robin pointer walks past locked slots. A per-slot used bit is kept as well. Once an insert leaves every slot marked used, those marks are cleared on all unlocked slots except the new one.

A diagnostic read port returns a slot's page table word, a packed tag word and its used bit one cycle after the request. The entry count must be a power of two from 2 to 64; any other value stops elaboration with an error.

Top module: `tlb_lock`

## Requirements
- R1: After reset every slot is invalid with its used bit clear, and the round-robin pointer is 0. `cmd_ready` is low while `rst` is high and high from the first cycle after it.
- R2: An accepted insert (`cmd_op`=0) first invalidates any valid slot whose address, size code, context, partition and real flag all equal the command's, and clears that slot's used bit.
- R3: An insert with `cmd_use_slot`=1 writes slot `cmd_slot` whatever its state, locked or valid. The pointer is unchanged.
- R4: An insert with `cmd_use_slot`=0 takes the lowest-numbered invalid slot, counting a slot freed by R2 in the same cycle. The pointer is unchanged.
- R5: If no slot is invalid, the insert takes the first unlocked slot in the order pointer+1, pointer+2, … (wrapping modulo N), never the pointer's own slot. That slot becomes the new pointer value. A slot is locked when bit `LOCK_BIT` (default 6) of its page table word is 1.
- R6: If none of those N-1 slots is unlocked, the insert writes slot N-1 and leaves the pointer unchanged.
- R7: The inserted slot becomes valid and used. If after the insert every slot's used bit is set, the used bits of all unlocked slots other than the inserted one are cleared.
- R8: A context demap (`cmd_op`=1) invalidates, and clears the used bit of, every slot whose partition and context both equal the command's, locked ones included.
- R9: A partition demap (`cmd_op`=2) invalidates, and clears the used bit of, every unlocked slot whose partition equals the command's. Locked slots keep their state.
- R10: A flush (`cmd_op`=3) clears the valid and used bits of every slot.
- R11: A read request (`rd_en`, `rd_slot`) gives `rd_resp`=1 in the next cycle, with `rd_pte`, `rd_tag` and `rd_used` taken from the slot state before any command accepted in the request cycle. For an invalid slot, `rd_pte` and `rd_tag` are all ones.
- R12: For a valid slot the tag word is built as follows: the virtual address ORed with the context in the low bits, the inverted size code in bits 57:56, zeros in bits 59:58, the real flag in bit 60, and the partition in bits 63:61.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 insert, 1 context demap, 2 partition demap, 3 flush |
| cmd_va | input | VA_W | Page-aligned virtual address |
| cmd_szc | input | 2 | Page-size code |
| cmd_ctx | input | CTX_W | Context number |
| cmd_part | input | 3 | Partition number |
| cmd_real | input | 1 | Real-mode flag |
| cmd_pte | input | PTE_W | Page table word, bit LOCK_BIT is the lock |
| cmd_use_slot | input | 1 | Insert into cmd_slot instead of a chosen slot |
| cmd_slot | input | log2(N_ENTRIES) | Slot named by the insert |
| rd_en | input | 1 | Diagnostic read request |
| rd_slot | input | log2(N_ENTRIES) | Slot to read |
| rd_resp | output | 1 | Read data valid, one cycle after rd_en |
| rd_pte | output | PTE_W | Page table word or all ones |
| rd_tag | output | 64 | Tag word or all ones |
| rd_used | output | 1 | Used bit of the slot |

## Verification
A command driven before a rising edge changes the array state at that edge. A read issued in the next cycle therefore sees the change. Its response is registered at the following edge, so `rd_resp`, `rd_pte`, `rd_tag` and `rd_used` are due exactly one cycle after `rd_en`, and they reflect the state before any command accepted alongside the read.

The reference model captures its expectation at the request edge, before it applies that edge's command. It compares the outputs at the falling edge one cycle later. A read issued together with an insert into the same slot therefore has to return the old contents.

// File: rtl/tlb_lock_pkg.sv
package tlb_lock_pkg;

  typedef enum logic [1:0] {
    OP_INSERT     = 2'd0,
    OP_DEMAP_CTX  = 2'd1,
    OP_DEMAP_PART = 2'd2,
    OP_FLUSH      = 2'd3
  } tlb_op_e;

  localparam int TAG_W    = 64;
  localparam int PART_W   = 3;
  localparam int SZC_W    = 2;
  localparam int SZC_LSB  = 56;
  localparam int REAL_POS = 60;
  localparam int PART_LSB = 61;

  // Packs one slot's identity into the diagnostic tag word.
  function automatic logic [TAG_W-1:0] pack_tag(
    input logic [TAG_W-1:0]  va_ext,
    input logic [TAG_W-1:0]  ctx_ext,
    input logic              real_f,
    input logic [PART_W-1:0] part,
    input logic [SZC_W-1:0]  szc
  );
    logic [TAG_W-1:0] t;
    t = va_ext | ctx_ext;
    t[SZC_LSB+SZC_W-1:SZC_LSB] = ~szc;
    t[59:58] = 2'b00;
    t[REAL_POS] = real_f;
    t[PART_LSB+PART_W-1:PART_LSB] = part;
    return t;
  endfunction

endpackage

// File: rtl/tlb_key_match.sv
module tlb_key_match
  import tlb_lock_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 48,
  parameter int CTX_W     = 13
) (
  input  logic [N_ENTRIES-1:0] valid_q,
  input  logic [N_ENTRIES-1:0] lock_vec,
  input  logic [VA_W-1:0]      va_q   [N_ENTRIES],
  input  logic [SZC_W-1:0]     szc_q  [N_ENTRIES],
  input  logic [CTX_W-1:0]     ctx_q  [N_ENTRIES],
  input  logic [PART_W-1:0]    part_q [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] real_q,
  input  logic [VA_W-1:0]      cmd_va,
  input  logic [SZC_W-1:0]     cmd_szc,
  input  logic [CTX_W-1:0]     cmd_ctx,
  input  logic [PART_W-1:0]    cmd_part,
  input  logic                 cmd_real,
  output logic [N_ENTRIES-1:0] key_hit,
  output logic [N_ENTRIES-1:0] ctx_hit,
  output logic [N_ENTRIES-1:0] part_hit
);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
    logic same_part;
    logic same_ctx;
    assign same_part   = (part_q[i] == cmd_part);
    assign same_ctx    = (ctx_q[i] == cmd_ctx);
    assign key_hit[i]  = valid_q[i] && same_part && same_ctx &&
                         (va_q[i] == cmd_va) && (szc_q[i] == cmd_szc) &&
                         (real_q[i] == cmd_real);
    assign ctx_hit[i]  = same_part && same_ctx;
    assign part_hit[i] = same_part && !lock_vec[i];
  end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] free_vec,
  input  logic [N_ENTRIES-1:0] lock_vec,
  input  logic [IDX_W-1:0]     last_q,
  input  logic                 use_slot,
  input  logic [IDX_W-1:0]     slot_req,
  output logic [IDX_W-1:0]     slot,
  output logic                 took_rr
);

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic             any_rr;
  logic [IDX_W-1:0] rr_idx;

  // Lowest-numbered free slot: scan downward so the last hit wins.
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // First unlocked slot after the pointer; the pointer's own slot is never a candidate.
  always_comb begin
    logic [IDX_W-1:0] cand;
    any_rr = 1'b0;
    rr_idx = '0;
    for (int k = N_ENTRIES - 1; k >= 1; k--) begin
      cand = last_q + IDX_W'(k);
      if (!lock_vec[cand]) begin
        any_rr = 1'b1;
        rr_idx = cand;
      end
    end
  end

  always_comb begin
    took_rr = 1'b0;
    if (use_slot) begin
      slot = slot_req;
    end else if (any_free) begin
      slot = free_idx;
    end else if (any_rr) begin
      slot    = rr_idx;
      took_rr = 1'b1;
    end else begin
      slot = IDX_W'(N_ENTRIES - 1);
    end
  end

endmodule

// File: rtl/tlb_diag_read.sv
module tlb_diag_read
  import tlb_lock_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 48,
  parameter int CTX_W     = 13,
  parameter int PTE_W     = 64,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_slot,
  input  logic [N_ENTRIES-1:0] valid_q,
  input  logic [N_ENTRIES-1:0] used_q,
  input  logic [VA_W-1:0]      va_q   [N_ENTRIES],
  input  logic [SZC_W-1:0]     szc_q  [N_ENTRIES],
  input  logic [CTX_W-1:0]     ctx_q  [N_ENTRIES],
  input  logic [PART_W-1:0]    part_q [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] real_q,
  input  logic [PTE_W-1:0]     pte_q  [N_ENTRIES],
  output logic                 rd_resp,
  output logic [PTE_W-1:0]     rd_pte,
  output logic [TAG_W-1:0]     rd_tag,
  output logic                 rd_used
);

  logic             sel_valid;
  logic [TAG_W-1:0] sel_tag;

  assign sel_valid = valid_q[rd_slot];
  assign sel_tag   = pack_tag(TAG_W'(va_q[rd_slot]), TAG_W'(ctx_q[rd_slot]),
                              real_q[rd_slot], part_q[rd_slot], szc_q[rd_slot]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_resp <= 1'b0;
      rd_pte  <= '1;
      rd_tag  <= '1;
      rd_used <= 1'b0;
    end else begin
      rd_resp <= rd_en;
      if (rd_en) begin
        rd_pte  <= sel_valid ? pte_q[rd_slot] : '1;
        rd_tag  <= sel_valid ? sel_tag : '1;
        rd_used <= used_q[rd_slot];
      end
    end
  end

endmodule

// File: rtl/tlb_lock.sv
module tlb_lock
  import tlb_lock_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 48,
  parameter int CTX_W     = 13,
  parameter int PTE_W     = 64,
  parameter int LOCK_BIT  = 6,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [SZC_W-1:0]  cmd_szc,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic [PART_W-1:0] cmd_part,
  input  logic              cmd_real,
  input  logic [PTE_W-1:0]  cmd_pte,
  input  logic              cmd_use_slot,
  input  logic [IDX_W-1:0]  cmd_slot,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_slot,
  output logic              rd_resp,
  output logic [PTE_W-1:0]  rd_pte,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_used
);

  if (N_ENTRIES < 2 || N_ENTRIES > 64 || (1 << IDX_W) != N_ENTRIES) begin : g_bad_entries
    $error("tlb_lock: N_ENTRIES must be a power of two from 2 to 64");
  end
  if (VA_W > SZC_LSB || CTX_W > VA_W || LOCK_BIT >= PTE_W) begin : g_bad_fields
    $error("tlb_lock: field widths do not fit the tag word");
  end

  // Slot state
  logic [N_ENTRIES-1:0] valid_q, used_q, real_q;
  logic [VA_W-1:0]      va_q   [N_ENTRIES];
  logic [SZC_W-1:0]     szc_q  [N_ENTRIES];
  logic [CTX_W-1:0]     ctx_q  [N_ENTRIES];
  logic [PART_W-1:0]    part_q [N_ENTRIES];
  logic [PTE_W-1:0]     pte_q  [N_ENTRIES];
  logic [IDX_W-1:0]     last_q;
  logic                 ready_q;

  // Named internal events
  logic                 accept, do_insert, do_ctx, do_part, do_flush;
  logic [N_ENTRIES-1:0] lock_vec, key_hit, ctx_hit, part_hit;
  logic [N_ENTRIES-1:0] free_vec, slot_oh, lock_after, used_set;
  logic [N_ENTRIES-1:0] valid_d, used_d;
  logic [IDX_W-1:0]     ins_slot;
  logic                 took_rr;
  logic                 used_full;

  assign cmd_ready = ready_q;
  assign accept    = cmd_valid && ready_q;
  assign do_insert = accept && (cmd_op == OP_INSERT);
  assign do_ctx    = accept && (cmd_op == OP_DEMAP_CTX);
  assign do_part   = accept && (cmd_op == OP_DEMAP_PART);
  assign do_flush  = accept && (cmd_op == OP_FLUSH);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_lock
    assign lock_vec[i] = pte_q[i][LOCK_BIT];
  end

  tlb_key_match #(.N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .CTX_W(CTX_W)) u_match (
    .valid_q (valid_q),
    .lock_vec(lock_vec),
    .va_q    (va_q),
    .szc_q   (szc_q),
    .ctx_q   (ctx_q),
    .part_q  (part_q),
    .real_q  (real_q),
    .cmd_va  (cmd_va),
    .cmd_szc (cmd_szc),
    .cmd_ctx (cmd_ctx),
    .cmd_part(cmd_part),
    .cmd_real(cmd_real),
    .key_hit (key_hit),
    .ctx_hit (ctx_hit),
    .part_hit(part_hit)
  );

  // A slot freed by the conflicting key counts as free in the same cycle.
  assign free_vec = ~(valid_q & ~key_hit);

  tlb_victim_sel #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .free_vec(free_vec),
    .lock_vec(lock_vec),
    .last_q  (last_q),
    .use_slot(cmd_use_slot),
    .slot_req(cmd_slot),
    .slot    (ins_slot),
    .took_rr (took_rr)
  );

  assign slot_oh    = N_ENTRIES'(1) << ins_slot;
  assign lock_after = (lock_vec & ~slot_oh) | (cmd_pte[LOCK_BIT] ? slot_oh : '0);
  assign used_set   = (used_q & ~key_hit) | slot_oh;
  assign used_full  = &used_set;

  always_comb begin
    valid_d = valid_q;
    used_d  = used_q;
    if (do_insert) begin
      valid_d = (valid_q & ~key_hit) | slot_oh;
      used_d  = used_full ? ((used_set & lock_after) | slot_oh) : used_set;
    end else if (do_ctx) begin
      valid_d = valid_q & ~ctx_hit;
      used_d  = used_q & ~ctx_hit;
    end else if (do_part) begin
      valid_d = valid_q & ~part_hit;
      used_d  = used_q & ~part_hit;
    end else if (do_flush) begin
      valid_d = '0;
      used_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      valid_q <= '0;
      used_q  <= '0;
      last_q  <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= valid_d;
      used_q  <= used_d;
      if (do_insert && took_rr) last_q <= ins_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      real_q <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        va_q[i]   <= '0;
        szc_q[i]  <= '0;
        ctx_q[i]  <= '0;
        part_q[i] <= '0;
        pte_q[i]  <= '0;
      end
    end else if (do_insert) begin
      va_q[ins_slot]   <= cmd_va;
      szc_q[ins_slot]  <= cmd_szc;
      ctx_q[ins_slot]  <= cmd_ctx;
      part_q[ins_slot] <= cmd_part;
      real_q[ins_slot] <= cmd_real;
      pte_q[ins_slot]  <= cmd_pte;
    end
  end

  tlb_diag_read #(.N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .CTX_W(CTX_W), .PTE_W(PTE_W)) u_diag (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_slot(rd_slot),
    .valid_q(valid_q),
    .used_q (used_q),
    .va_q   (va_q),
    .szc_q  (szc_q),
    .ctx_q  (ctx_q),
    .part_q (part_q),
    .real_q (real_q),
    .pte_q  (pte_q),
    .rd_resp(rd_resp),
    .rd_pte (rd_pte),
    .rd_tag (rd_tag),
    .rd_used(rd_used)
  );

endmodule

// File: rtl/tlb_lock_chk.sv
module tlb_lock_chk
  import tlb_lock_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PTE_W     = 64,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 accept,
  input logic [1:0]           cmd_op,
  input logic                 rd_en,
  input logic [IDX_W-1:0]     rd_slot,
  input logic                 rd_resp,
  input logic [PTE_W-1:0]     rd_pte,
  input logic [TAG_W-1:0]     rd_tag,
  input logic [N_ENTRIES-1:0] valid_q,
  input logic [N_ENTRIES-1:0] used_q,
  input logic [N_ENTRIES-1:0] lock_vec,
  input logic [N_ENTRIES-1:0] key_hit,
  input logic [N_ENTRIES-1:0] ctx_hit,
  input logic [N_ENTRIES-1:0] part_hit,
  input logic [IDX_W-1:0]     ins_slot,
  input logic                 took_rr
);

  assert_key_unique_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(key_hit));

  assert_rr_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_INSERT && took_rr) |-> !lock_vec[ins_slot]);

  assert_insert_marks_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_INSERT) |=> (valid_q[$past(ins_slot)] && used_q[$past(ins_slot)]));

  assert_ctx_demap_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_DEMAP_CTX) |=> ((valid_q & $past(ctx_hit)) == '0));

  assert_part_demap_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_DEMAP_PART) |=> ((valid_q & $past(part_hit)) == '0));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_FLUSH) |=> (valid_q == '0 && used_q == '0));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_resp);

  assert_invalid_ones_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !valid_q[rd_slot]) |=> (rd_pte == '1 && rd_tag == '1));

endmodule

bind tlb_lock tlb_lock_chk #(.N_ENTRIES(N_ENTRIES), .PTE_W(PTE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .accept  (accept),
  .cmd_op  (cmd_op),
  .rd_en   (rd_en),
  .rd_slot (rd_slot),
  .rd_resp (rd_resp),
  .rd_pte  (rd_pte),
  .rd_tag  (rd_tag),
  .valid_q (valid_q),
  .used_q  (used_q),
  .lock_vec(lock_vec),
  .key_hit (key_hit),
  .ctx_hit (ctx_hit),
  .part_hit(part_hit),
  .ins_slot(ins_slot),
  .took_rr (took_rr)
);

// File: tb/tlb_lock_tb.sv
module tlb_lock_tb;
  import tlb_lock_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;
  localparam int IW = 4;
  localparam int LK = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [47:0] cmd_va = '0;
  logic [1:0] cmd_szc = '0;
  logic [12:0] cmd_ctx = '0;
  logic [2:0] cmd_part = '0;
  logic cmd_real = 1'b0;
  logic [63:0] cmd_pte = '0;
  logic cmd_use_slot = 1'b0;
  logic [IW-1:0] cmd_slot = '0;
  logic rd_en = 1'b0;
  logic [IW-1:0] rd_slot = '0;
  logic rd_resp;
  logic [63:0] rd_pte, rd_tag;
  logic rd_used;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_lock u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_szc(cmd_szc), .cmd_ctx(cmd_ctx),
    .cmd_part(cmd_part), .cmd_real(cmd_real), .cmd_pte(cmd_pte),
    .cmd_use_slot(cmd_use_slot), .cmd_slot(cmd_slot), .rd_en(rd_en),
    .rd_slot(rd_slot), .rd_resp(rd_resp), .rd_pte(rd_pte), .rd_tag(rd_tag),
    .rd_used(rd_used)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  // Behavioural reference model
  bit          mv [NE];
  bit          mu [NE];
  logic [47:0] mva [NE];
  int          mszc [NE];
  int          mctx [NE];
  int          mpart [NE];
  bit          mreal [NE];
  logic [63:0] mpte [NE];
  int          mlast;
  bit          pend;
  logic [63:0] exp_pte, exp_tag;
  bit          exp_used;

  function automatic logic [47:0] key_va(int k);
    logic [47:0] v;
    v = 48'(k * 37 + 5);
    return v << 13;
  endfunction

  function automatic logic [63:0] key_pte(int k, bit lk);
    logic [63:0] p;
    p = {32'hC0DE0000 | 32'(k), 32'(k * 9 + 1)};
    p[LK] = lk;
    return p;
  endfunction

  function automatic logic [63:0] model_tag(int s);
    logic [63:0] t;
    t = 64'(mva[s]) | 64'(mctx[s]);
    t = t | (64'(mreal[s]) << 60);
    t = t | (64'(mpart[s]) << 61);
    t = t | (64'((~mszc[s]) & 3) << 56);
    return t;
  endfunction

  task automatic check64(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NE; i++) begin
        mv[i] = 0; mu[i] = 0; mva[i] = '0; mszc[i] = 0; mctx[i] = 0;
        mpart[i] = 0; mreal[i] = 0; mpte[i] = '0;
      end
      mlast = 0;
      pend = 0;
    end else begin
      pend = rd_en;
      if (rd_en) begin
        exp_pte  = mv[rd_slot] ? mpte[rd_slot] : '1;
        exp_tag  = mv[rd_slot] ? model_tag(int'(rd_slot)) : '1;
        exp_used = mu[rd_slot];
      end
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin
            int s;
            bit all;
            for (int i = 0; i < NE; i++)
              if (mv[i] && mva[i] == cmd_va && mszc[i] == int'(cmd_szc) &&
                  mctx[i] == int'(cmd_ctx) && mpart[i] == int'(cmd_part) &&
                  mreal[i] == cmd_real) begin
                mv[i] = 0; mu[i] = 0;
              end
            s = -1;
            if (cmd_use_slot) s = int'(cmd_slot);
            else begin
              for (int i = 0; i < NE; i++) if (s < 0 && !mv[i]) s = i;
              if (s < 0) begin
                for (int k = 1; k < NE; k++)
                  if (s < 0 && !mpte[(mlast + k) % NE][LK]) s = (mlast + k) % NE;
                if (s < 0) s = NE - 1;
                else mlast = s;
              end
            end
            mva[s] = cmd_va; mszc[s] = int'(cmd_szc); mctx[s] = int'(cmd_ctx);
            mpart[s] = int'(cmd_part); mreal[s] = cmd_real; mpte[s] = cmd_pte;
            mv[s] = 1; mu[s] = 1;
            all = 1;
            for (int i = 0; i < NE; i++) all = all & mu[i];
            if (all)
              for (int i = 0; i < NE; i++) if (i != s && !mpte[i][LK]) mu[i] = 0;
          end
          2'd1: for (int i = 0; i < NE; i++)
                  if (mpart[i] == int'(cmd_part) && mctx[i] == int'(cmd_ctx)) begin
                    mv[i] = 0; mu[i] = 0;
                  end
          2'd2: for (int i = 0; i < NE; i++)
                  if (mpart[i] == int'(cmd_part) && !mpte[i][LK]) begin
                    mv[i] = 0; mu[i] = 0;
                  end
          default: for (int i = 0; i < NE; i++) begin mv[i] = 0; mu[i] = 0; end
        endcase
      end
    end
  end

  // Compare one cycle after each read request (R11 latency), at the falling edge.
  always @(negedge clk) begin
    if (!rst && pend && !finished) begin
      check64({"R11 resp ", cur_req}, 64'(rd_resp), 64'd1);
      check64({"pte ", cur_req}, rd_pte, exp_pte);
      check64({"R12 tag ", cur_req}, rd_tag, exp_tag);
      check64({"used ", cur_req}, 64'(rd_used), 64'(exp_used));
    end
  end

  task automatic drive(bit v, logic [1:0] op, int k, bit lk, bit us, int sl, bit re, int rs);
    @(negedge clk);
    cmd_valid = v; cmd_op = op;
    cmd_va = key_va(k); cmd_szc = 2'(k % 4); cmd_ctx = 13'(k % 5);
    cmd_part = 3'(k % 3); cmd_real = (k % 2) == 1; cmd_pte = key_pte(k, lk);
    cmd_use_slot = us; cmd_slot = IW'(sl);
    rd_en = re; rd_slot = IW'(rs);
  endtask

  task automatic ins(int k, bit lk);            drive(1, 2'd0, k, lk, 0, 0, 0, 0); endtask
  task automatic ins_at(int k, bit lk, int sl); drive(1, 2'd0, k, lk, 1, sl, 0, 0); endtask
  task automatic idle();                        drive(0, 2'd0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(int s);                     drive(0, 2'd0, 0, 0, 0, 0, 1, s); endtask
  task automatic rd_all();
    for (int s = 0; s < NE; s++) rd(s);
    idle(); idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check64("R1 cmd_ready after reset", 64'(cmd_ready), 64'd1);
    rd_all();

    // R4: fill from empty, lowest free slot each time; slots 3 and 4 locked
    cur_req = "R4";
    for (int k = 0; k < NE; k++) ins(100 + k, (k == 3 || k == 4));
    idle();
    rd_all();
    // R7: saturation cleared used bits of unlocked slots except slot 15
    cur_req = "R7";
    rd_all();

    // R5: full array, round robin from pointer 0, skipping locked 3 and 4
    cur_req = "R5";
    ins(200, 0); ins(201, 0); ins(202, 0);
    idle();
    rd_all();

    // R2: same key as slot 7 frees it and lowest free reuses it
    cur_req = "R2";
    drive(1, 2'd0, 107, 0, 0, 0, 0, 0);
    cmd_pte = 64'h1234_5678_0000_0001;
    idle();
    rd(7); idle(); idle();

    // R3: explicit slot overrides; conflicting slot 8 drops, slot 10 written
    cur_req = "R3";
    ins_at(108, 0, 10);
    ins_at(300, 0, 3);      // locked slot overwritten
    idle();
    rd_all();
    cur_req = "R4";
    ins(301, 0);            // lowest free is slot 8
    idle();
    rd_all();

    // R11: read in the same cycle as an insert to that slot sees old contents
    cur_req = "R11";
    drive(1, 2'd0, 302, 0, 1, 6, 1, 6);
    idle(); idle();
    rd(6); idle(); idle();

    // R8: context demap, includes locked slot 4 (key 104: part 2, ctx 4)
    cur_req = "R8";
    drive(1, 2'd1, 104, 0, 0, 0, 0, 0);
    idle();
    rd_all();

    // R9: partition demap of partition 0 leaves locked slots alone
    cur_req = "R9";
    ins_at(402, 1, 4);      // key 402: partition 0, locked
    drive(1, 2'd2, 300, 0, 0, 0, 0, 0);
    idle();
    rd_all();

    // R6: every slot locked, inserts land on the last slot
    cur_req = "R10";
    drive(1, 2'd3, 0, 0, 0, 0, 0, 0);
    idle();
    rd_all();
    cur_req = "R6";
    for (int k = 0; k < NE; k++) ins(500 + k, 1);
    ins(600, 1);
    idle();
    rd_all();
    cur_req = "R5";
    ins_at(601, 0, 9);      // only slot 9 unlocked
    ins(602, 1);            // round robin picks 9, pointer becomes 9
    idle();
    rd_all();
    cur_req = "R6";
    ins(603, 0);            // slot 9 is the pointer itself: falls to slot 15
    idle();
    rd_all();

    cur_req = "R10";
    drive(1, 2'd3, 0, 0, 0, 0, 0, 0);
    idle();
    rd_all();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule